// File: doc/BRIEF.md
# Sidetone Loopback Mixer

This block sits between the receive and transmit sample paths of a four-slot, single-phase TDM serial port. Two receive slots are picked as loopback sources. Each picked sample is brought to a fixed 24-bit loop width, run through an 8-tap FIR filter and then scaled by a gain set for that channel. The result is held until a transmit sample for the matching destination slot arrives from the transmit buffer. That transmit sample is brought to the loop width, the held value is added to it, and the sum is packed back into the programmed serial word before it goes to the transmit shift register.

Configuration arrives as static inputs driven by a register file. The inputs are an enable, a word-length code, two source-slot selects, two destination-slot selects and two gains. Filter coefficients are written through a single write port with an index that advances on each write. Both channels use the same coefficient set. While the enable is low, transmit words pass through untouched, and the filter history and held results are forced to zero.

Top module: `sidetone_mixer`

## Requirements
- R1: With `word_len` = 0 (16-bit words) a serial word contributes its bits [15:0] as the upper 16 bits of the 24-bit loop sample, with 8 zero bits below. A mixed output word carries loop bits [23:8] in its bits [15:0], with zeros above.
- R2: With `word_len` = 2 or 3 (32-bit words) a serial word contributes its bits [31:8] as the loop sample, so the low 8 bits are dropped. A mixed output word carries the 24-bit loop sum in bits [31:8], with zeros in bits [7:0].
- R3: Each accepted loopback sample is shifted into that channel's 8-deep history, newest first. The filter output is the sum over taps i of history[i]·coef[i], arithmetically shifted right by 15. Coefficients are written in tap order 0..7 through `coef_we`/`coef_wdata`, the index advancing by one per write and wrapping from 7 to 0. Both channels use the same coefficients.
- R4: The filter output is multiplied by that channel's signed Q1.15 gain and arithmetically shifted right by 15. `gain0` applies to channel 0 and `gain1` to channel 1.
- R5: The filter output, the gained result and the transmit sum each saturate to the signed 24-bit range [-8388608, 8388607] instead of wrapping.
- R6: With `word_len` = 1 (24-bit words) the loop sample is word bits [23:0]. An output word for a destination slot is {8'h00, sat(loop(tx) + held result)}.
- R7: While `st_en` is low, every transmit word leaves unchanged. Filter history and held results become zero one clock after `st_en` is low, and receive samples taken during that time have no effect.
- R8: A transmit slot that matches neither destination select leaves unchanged. A destination select of 4 to 7 matches no slot. A receive sample on a slot that matches neither source select changes nothing.
- R9: `txo_valid` is high exactly one clock after `tx_valid`, and `txo_slot` repeats the slot accepted on that edge.
- R10: After reset `txo_valid`, `txo_slot` and `txo_data` are zero, and all held results and history are zero.
- R11: If both destination selects name the same slot, only channel 0's result is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_en | input | 1 | Loopback enable |
| word_len | input | 2 | Serial word length: 0=16, 1=24, 2/3=32 bits |
| in0_sel | input | 2 | Source receive slot for channel 0 |
| in1_sel | input | 2 | Source receive slot for channel 1 |
| out0_sel | input | 3 | Destination transmit slot for channel 0 (4..7 = none) |
| out1_sel | input | 3 | Destination transmit slot for channel 1 (4..7 = none) |
| gain0 | input | 16 | Channel 0 gain, signed Q1.15 |
| gain1 | input | 16 | Channel 1 gain, signed Q1.15 |
| coef_we | input | 1 | Coefficient write strobe |
| coef_wdata | input | 16 | Coefficient value, signed Q1.15 |
| rx_valid | input | 1 | Receive word valid |
| rx_slot | input | 2 | Slot number of the receive word |
| rx_data | input | 32 | Receive word, right-aligned |
| tx_valid | input | 1 | Transmit-buffer word valid |
| tx_slot | input | 2 | Slot number of the transmit word |
| tx_data | input | 32 | Transmit word, right-aligned |
| txo_valid | output | 1 | Word toward the shift register valid |
| txo_slot | output | 2 | Slot number of that word |
| txo_data | output | 32 | Mixed or passed-through transmit word |

## Verification
The embedded assertions check the timing-shaped rules on every cycle: the one-clock output latency and slot echo, pass-through while disabled, pass-through for slots with no destination, zeroed channel state after a disabled cycle, and the wrap of the coefficient index. The arithmetic can only be shown by the bench's sweeps, which compare against values computed in the bench. These sweeps cover the tap ordering under an impulse, padding and truncation for each word length, signed gains at their extremes, saturation at both rails, cleared history after re-enabling, and channel 0 priority on a shared destination.

// File: rtl/st_pkg.sv
package st_pkg;

    localparam int LOOP_W = 24;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        WL_16  = 2'd0,
        WL_24  = 2'd1,
        WL_32  = 2'd2,
        WL_32X = 2'd3
    } wlen_e;

    // serial word -> 24-bit loop sample (pad or truncate low bits)
    function automatic logic [LOOP_W-1:0] to_loop(input logic [1:0] wl,
                                                  input logic [WORD_W-1:0] w);
        logic [LOOP_W-1:0] r;
        case (wlen_e'(wl))
            WL_16:   r = {w[15:0], 8'h00};
            WL_24:   r = w[23:0];
            default: r = w[31:8];
        endcase
        return r;
    endfunction

    // 24-bit loop sample -> serial word in the programmed length
    function automatic logic [WORD_W-1:0] from_loop(input logic [1:0] wl,
                                                    input logic [LOOP_W-1:0] s);
        logic [WORD_W-1:0] r;
        case (wlen_e'(wl))
            WL_16:   r = {16'h0000, s[23:8]};
            WL_24:   r = {8'h00, s};
            default: r = {s, 8'h00};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/st_coef_bank.sv
module st_coef_bank #(
    parameter int TAPS = 8,
    parameter int CW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CW-1:0]        wdata,
    output logic [TAPS*CW-1:0]   coefs
);

    localparam int IW = (TAPS > 1) ? $clog2(TAPS) : 1;

    typedef struct packed {
        logic [IW-1:0]       idx;
        logic [TAPS*CW-1:0]  c;
    } cb_t;

    cb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            s_d.c[s_q.idx*CW +: CW] = wdata;
            s_d.idx = (s_q.idx == IW'(TAPS-1)) ? '0 : s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign coefs = s_q.c;

    // R3
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && s_q.idx == IW'(TAPS-1)) |=> (s_q.idx == '0));

    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(s_q.idx));

endmodule

// File: rtl/st_fir_chan.sv
module st_fir_chan #(
    parameter int TAPS = 8,
    parameter int LW   = 24,
    parameter int CW   = 16,
    parameter int GW   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                take,
    input  logic [LW-1:0]       sample,
    input  logic [TAPS*CW-1:0]  coefs,
    input  logic [GW-1:0]       gain,
    output logic [LW-1:0]       result
);

    localparam int TB = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam int AW = LW + CW + TB;
    localparam int PW = LW + GW;
    localparam int XW = (AW > PW) ? AW : PW;

    typedef struct packed {
        logic [TAPS*LW-1:0] hist;
        logic [LW-1:0]      res;
    } ch_t;

    ch_t ch_d, ch_q;

    logic [TAPS*LW-1:0]      h_next;
    logic signed [LW+CW-1:0] tap_p;
    logic signed [AW-1:0]    acc;
    logic [LW-1:0]           fir_s;
    logic signed [PW-1:0]    prod;
    logic [LW-1:0]           gain_s;

    function automatic logic [LW-1:0] sat(input logic signed [XW-1:0] v);
        logic signed [XW-1:0] hi, lo;
        hi = {{(XW-LW+1){1'b0}}, {(LW-1){1'b1}}};
        lo = {{(XW-LW+1){1'b1}}, {(LW-1){1'b0}}};
        if (v > hi)      return hi[LW-1:0];
        else if (v < lo) return lo[LW-1:0];
        else             return v[LW-1:0];
    endfunction

    generate
        if (TAPS > 1) begin : g_shift
            assign h_next = {ch_q.hist[(TAPS-1)*LW-1:0], sample};
        end else begin : g_single
            assign h_next = sample;
        end
    endgenerate

    always_comb begin
        acc   = '0;
        tap_p = '0;
        for (int i = 0; i < TAPS; i++) begin
            tap_p = $signed(h_next[i*LW +: LW]) * $signed(coefs[i*CW +: CW]);
            acc   = acc + AW'(tap_p);
        end
        fir_s  = sat(XW'(acc >>> (CW-1)));
        prod   = $signed(fir_s) * $signed(gain);
        gain_s = sat(XW'(prod >>> (GW-1)));

        ch_d = ch_q;
        if (!en) begin
            ch_d = '0;
        end else if (take) begin
            ch_d.hist = h_next;
            ch_d.res  = gain_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign result = ch_q.res;

    // R7
    dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (result == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !take) |=> $stable(result));

endmodule

// File: rtl/st_tx_mix.sv
module st_tx_mix
    import st_pkg::*;
#(
    parameter int SLOT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [1:0]           wlen,
    input  logic [SLOT_W:0]      out_sel0,
    input  logic [SLOT_W:0]      out_sel1,
    input  logic [LOOP_W-1:0]    side0,
    input  logic [LOOP_W-1:0]    side1,
    input  logic                 tx_valid,
    input  logic [SLOT_W-1:0]    tx_slot,
    input  logic [WORD_W-1:0]    tx_data,
    output logic                 txo_valid,
    output logic [SLOT_W-1:0]    txo_slot,
    output logic [WORD_W-1:0]    txo_data
);

    typedef struct packed {
        logic                valid;
        logic [SLOT_W-1:0]   slot;
        logic [WORD_W-1:0]   data;
    } mx_t;

    mx_t mx_d, mx_q;

    logic                     hit0, hit1;
    logic [LOOP_W-1:0]        base, add, sum_s;
    logic signed [LOOP_W:0]   sum_w;

    always_comb begin
        hit0  = en && (out_sel0 == {1'b0, tx_slot});
        hit1  = en && (out_sel1 == {1'b0, tx_slot});
        add   = hit0 ? side0 : side1;
        base  = to_loop(wlen, tx_data);
        sum_w = $signed({base[LOOP_W-1], base}) + $signed({add[LOOP_W-1], add});
        if (sum_w[LOOP_W] != sum_w[LOOP_W-1])
            sum_s = sum_w[LOOP_W] ? {1'b1, {(LOOP_W-1){1'b0}}} : {1'b0, {(LOOP_W-1){1'b1}}};
        else
            sum_s = sum_w[LOOP_W-1:0];

        mx_d       = mx_q;
        mx_d.valid = tx_valid;
        if (tx_valid) begin
            mx_d.slot = tx_slot;
            mx_d.data = (hit0 || hit1) ? from_loop(wlen, sum_s) : tx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mx_q <= '0;
        else        mx_q <= mx_d;
    end

    assign txo_valid = mx_q.valid;
    assign txo_slot  = mx_q.slot;
    assign txo_data  = mx_q.data;

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> (txo_valid && txo_slot == $past(tx_slot)));

    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> !txo_valid);

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !en) |=> (txo_data == $past(tx_data)));

    // R8
    unrouted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && out_sel0[SLOT_W] && out_sel1[SLOT_W]) |=> (txo_data == $past(tx_data)));

endmodule

// File: rtl/sidetone_mixer.sv
module sidetone_mixer
    import st_pkg::*;
#(
    parameter int TAPS   = 8,
    parameter int CW     = 16,
    parameter int GW     = 16,
    parameter int SLOT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_en,
    input  logic [1:0]           word_len,
    input  logic [SLOT_W-1:0]    in0_sel,
    input  logic [SLOT_W-1:0]    in1_sel,
    input  logic [SLOT_W:0]      out0_sel,
    input  logic [SLOT_W:0]      out1_sel,
    input  logic [GW-1:0]        gain0,
    input  logic [GW-1:0]        gain1,
    input  logic                 coef_we,
    input  logic [CW-1:0]        coef_wdata,
    input  logic                 rx_valid,
    input  logic [SLOT_W-1:0]    rx_slot,
    input  logic [WORD_W-1:0]    rx_data,
    input  logic                 tx_valid,
    input  logic [SLOT_W-1:0]    tx_slot,
    input  logic [WORD_W-1:0]    tx_data,
    output logic                 txo_valid,
    output logic [SLOT_W-1:0]    txo_slot,
    output logic [WORD_W-1:0]    txo_data
);

    localparam int NCH = 2;

    logic [TAPS*CW-1:0]   coefs;
    logic [LOOP_W-1:0]    rx_loop;
    logic [SLOT_W-1:0]    src_sel [NCH];
    logic [GW-1:0]        ch_gain [NCH];
    logic [LOOP_W-1:0]    side    [NCH];

    assign rx_loop    = to_loop(word_len, rx_data);
    assign src_sel[0] = in0_sel;
    assign src_sel[1] = in1_sel;
    assign ch_gain[0] = gain0;
    assign ch_gain[1] = gain1;

    st_coef_bank #(.TAPS(TAPS), .CW(CW)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .wdata (coef_wdata),
        .coefs (coefs)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            st_fir_chan #(.TAPS(TAPS), .LW(LOOP_W), .CW(CW), .GW(GW)) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (st_en),
                .take   (rx_valid && rx_slot == src_sel[g]),
                .sample (rx_loop),
                .coefs  (coefs),
                .gain   (ch_gain[g]),
                .result (side[g])
            );
        end
    endgenerate

    st_tx_mix #(.SLOT_W(SLOT_W)) u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (st_en),
        .wlen      (word_len),
        .out_sel0  (out0_sel),
        .out_sel1  (out1_sel),
        .side0     (side[0]),
        .side1     (side[1]),
        .tx_valid  (tx_valid),
        .tx_slot   (tx_slot),
        .tx_data   (tx_data),
        .txo_valid (txo_valid),
        .txo_slot  (txo_slot),
        .txo_data  (txo_data)
    );

endmodule

// File: tb/sim_sidetone_mixer.sv
module sim_sidetone_mixer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_en = 1'b0;
    logic [1:0]  word_len = 2'd1;
    logic [1:0]  in0_sel = 2'd0, in1_sel = 2'd1;
    logic [2:0]  out0_sel = 3'd2, out1_sel = 3'd3;
    logic [15:0] gain0 = '0, gain1 = '0;
    logic        coef_we = 1'b0;
    logic [15:0] coef_wdata = '0;
    logic        rx_valid = 1'b0;
    logic [1:0]  rx_slot = '0;
    logic [31:0] rx_data = '0;
    logic        tx_valid = 1'b0;
    logic [1:0]  tx_slot = '0;
    logic [31:0] tx_data = '0;
    logic        txo_valid;
    logic [1:0]  txo_slot;
    logic [31:0] txo_data;

    int errors = 0;
    int checks = 0;
    int unsigned seed = 32'h1234_5678;

    longint mh [2][8];
    longint mst [2];
    longint mc [8];

    always #5 clk = ~clk;

    sidetone_mixer u0 (.*);

    function automatic longint sat24(input longint v);
        if (v > 64'sd8388607)  return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    function automatic longint nrm(input int wl, input logic [31:0] d);
        if (wl == 0)      return longint'($signed(d[15:0])) * 256;
        else if (wl == 1) return longint'($signed(d[23:0]));
        else              return longint'($signed(d)) >>> 8;
    endfunction

    function automatic logic [31:0] fmt(input int wl, input longint s);
        if (wl == 0)      return 32'((s >>> 8) & 64'hFFFF);
        else if (wl == 1) return 32'(s & 64'hFFFFFF);
        else              return 32'((s & 64'hFFFFFF) << 8);
    endfunction

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 2; k++) begin
            mst[k] = 0;
            for (int t = 0; t < 8; t++) mh[k][t] = 0;
        end
    endtask

    task automatic wcoef(input int base, input int step);
        for (int i = 0; i < 8; i++) begin
            coef_we    = 1'b1;
            coef_wdata = 16'(base + i*step);
            mc[i]      = longint'($signed(coef_wdata));
            @(negedge clk);
        end
        coef_we = 1'b0;
    endtask

    task automatic rx(input logic [1:0] sl, input logic [31:0] d);
        rx_valid = 1'b1; rx_slot = sl; rx_data = d;
        if (st_en) begin
            for (int k = 0; k < 2; k++) begin
                if (sl == (k == 0 ? in0_sel : in1_sel)) begin
                    longint acc, f, gk;
                    for (int t = 7; t > 0; t--) mh[k][t] = mh[k][t-1];
                    mh[k][0] = nrm(int'(word_len), d);
                    acc = 0;
                    for (int t = 0; t < 8; t++) acc += mh[k][t] * mc[t];
                    f  = sat24(acc >>> 15);
                    gk = longint'($signed(k == 0 ? gain0 : gain1));
                    mst[k] = sat24((f * gk) >>> 15);
                end
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tx(input string tag, input logic [1:0] sl, input logic [31:0] d);
        logic [31:0] exp;
        int ch;
        ch = -1;
        if (st_en) begin
            if (out0_sel == {1'b0, sl})      ch = 0;
            else if (out1_sel == {1'b0, sl}) ch = 1;
        end
        if (ch < 0) exp = d;
        else exp = fmt(int'(word_len), sat24(nrm(int'(word_len), d) + mst[ch]));
        tx_valid = 1'b1; tx_slot = sl; tx_data = d;
        @(negedge clk);
        check(tag, txo_data, exp);
        check("R9 valid", {31'b0, txo_valid}, 32'd1);
        check("R9 slot", {30'b0, txo_slot}, {30'b0, sl});
        tx_valid = 1'b0;
    endtask

    task automatic tx_all(input string tag);
        for (int s = 0; s < 4; s++) tx(tag, 2'(s), rnd());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_clear();
        for (int i = 0; i < 8; i++) mc[i] = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 valid", {31'b0, txo_valid}, 32'd0);
        check("R10 slot", {30'b0, txo_slot}, 32'd0);
        check("R10 data", txo_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 impulse shows tap order; R4 per-channel gains
        gain0 = 16'sd32767; gain1 = -16'sd16384;
        wcoef(1000, 4000);
        st_en = 1'b1;
        @(negedge clk);
        tx("R10 cleared history", 2'd2, 32'h0012_3456);
        rx(2'd0, 32'h0010_0000);
        rx(2'd1, 32'h0008_0000);
        tx_all("R3 impulse");
        for (int n = 0; n < 9; n++) begin
            rx(2'd0, 32'h0);
            rx(2'd1, 32'h0);
            tx("R3 tap", 2'd2, 32'h0000_0100);
            tx("R4 tap", 2'd3, 32'h00FF_FF00);
        end

        // R1 / R6 / R2 word-length sweeps with random data
        for (int wl = 0; wl < 4; wl++) begin
            word_len = 2'(wl);
            for (int n = 0; n < 20; n++) begin
                rx(2'(n % 4), rnd());
                rx(2'((n + 1) % 4), rnd());
                if (wl == 0)      tx_all("R1 16-bit");
                else if (wl == 1) tx_all("R6 24-bit");
                else              tx_all("R2 32-bit");
            end
        end

        // R4 gain sweep
        word_len = 2'd1;
        wcoef(32767, -3000);
        for (int gi = 0; gi < 5; gi++) begin
            case (gi)
                0: begin gain0 = 16'h0000; gain1 = 16'h4000; end
                1: begin gain0 = 16'h8000; gain1 = 16'h7FFF; end
                2: begin gain0 = 16'h7FFF; gain1 = 16'h8000; end
                3: begin gain0 = 16'hC000; gain1 = 16'h2000; end
                default: begin gain0 = 16'h1234; gain1 = 16'hEDCB; end
            endcase
            for (int n = 0; n < 6; n++) begin
                rx(2'd0, rnd());
                rx(2'd1, rnd());
                tx("R4 gain ch0", 2'd2, rnd());
                tx("R4 gain ch1", 2'd3, rnd());
            end
        end

        // R5 saturation at both rails
        wcoef(32767, 0);
        gain0 = 16'h7FFF; gain1 = 16'h7FFF;
        for (int n = 0; n < 4; n++) begin
            rx(2'd0, 32'h007F_FFFF);
            rx(2'd1, 32'h0080_0000);
        end
        tx("R5 pos rail", 2'd2, 32'h007F_FFFF);
        tx("R5 neg rail", 2'd3, 32'h0080_0000);
        tx("R5 pos cancel", 2'd2, 32'h0080_0000);
        tx("R5 neg cancel", 2'd3, 32'h007F_FFFF);

        // R7 disable: pass-through, rx ignored, history cleared
        st_en = 1'b0;
        @(negedge clk);
        model_clear();
        for (int n = 0; n < 6; n++) begin
            rx(2'd0, rnd());
            tx_all("R7 bypass");
        end
        st_en = 1'b1;
        @(negedge clk);
        tx("R7 cleared ch0", 2'd2, 32'h0000_1234);
        tx("R7 cleared ch1", 2'd3, 32'h00AB_CDEF);
        wcoef(8192, 1024);
        gain0 = 16'h4000; gain1 = 16'h7FFF;
        rx(2'd0, 32'h0040_0000);
        tx("R7 fresh history", 2'd2, 32'h0000_0010);

        // R8 unassigned destinations and sources
        out1_sel = 3'd5;
        rx(2'd1, 32'h0030_0000);
        tx("R8 sel above 3", 2'd3, 32'h0055_AA55);
        in0_sel = 2'd2; in1_sel = 2'd2;
        rx(2'd0, 32'h007F_0000);
        tx("R8 unused source", 2'd2, 32'h0000_0001);
        out0_sel = 3'd7; out1_sel = 3'd6;
        rx(2'd2, 32'h0011_1111);
        tx_all("R8 no destination");

        // R11 shared destination
        out0_sel = 3'd1; out1_sel = 3'd1;
        in0_sel = 2'd0; in1_sel = 2'd3;
        for (int n = 0; n < 4; n++) begin
            rx(2'd0, rnd());
            rx(2'd3, rnd());
            tx("R11 priority", 2'd1, rnd());
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule